// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block keeps the status byte of a serial nonvolatile memory: a busy flag, a write-enable latch, a two-bit protected-range selector and a lock-enable bit. It carries out the four status commands that the command decoder hands it: set the write-enable latch, clear it, read the status byte and write the status byte. Status writes go through a timed internal write cycle, and the new values take effect only when that cycle ends. A pin-driven lock can freeze the status byte, but it has no effect on the memory array.

The block also answers a combinational question for the page write engine: may the byte at a given address be written right now? The answer is yes only when the write-enable latch is set and the address lies outside the range picked by the protect bits. The engine reports its own write cycles through `arr_busy` and `arr_done`. A finished array write clears the write-enable latch.

Commands arrive on a valid/ready stream. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Status-read results leave on a second valid/ready stream. `rsp_data` holds still while `rsp_valid` is high and `rsp_ready` is low. `cmd_ready` is low only while an unread result waits, so back-pressure on the result stream stalls every command. The reset input stands for the initial state, and it brings the protect and lock bits to 0.

Top module: `sr_protect_unit`

## Requirements
- R1: After reset, `busy` and `wen` are 0, `rsp_valid` is 0, `chk_writable` is 0 for every address, and a status read returns 0x00.
- R2: Command code 2'b00 sets the write-enable latch and 2'b01 clears it. The `wen` output and status bit 1 show the latch.
- R3: Command code 2'b10 returns the status byte. Bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect selector, bit 7 is the lock-enable bit, and bits 6:4 read 0 while idle.
- R4: A status write (code 2'b11, new value on `cmd_data`) is carried out only when the write-enable latch is 1 and the lock is inactive. The lock is active when `wp_n` is 0 and the lock-enable bit is 1. Otherwise the command changes no state and starts no cycle.
- R5: An accepted status write raises `busy` in the next cycle and holds it for WR_CYCLES cycles. The stored bits keep their old values until the cycle ends. A status read taken while `busy` is high returns 0xFF.
- R6: When a status write cycle ends, only `cmd_data` bits 7, 3 and 2 are stored, and the write-enable latch clears.
- R7: While `busy` is high, either from a status write or from `arr_busy`, commands 2'b00, 2'b01 and 2'b11 are accepted and discarded.
- R8: A one-cycle pulse on `arr_done` clears the write-enable latch.
- R9: Protect selector 00 guards nothing. Selector 01 guards the top quarter of the address space (0xC00..0xFFF at default width), 10 guards the top half (0x800..0xFFF), and 11 guards everything. `chk_writable` is 1 only when the latch is set and `chk_addr` is outside the guarded range.
- R10: `wp_n` has no effect on `chk_writable`.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` holds steady and `cmd_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (initial state) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | Command code: 00 set latch, 01 clear latch, 10 read, 11 write |
| cmd_data | input | 8 | New status value for a write |
| rsp_valid | output | 1 | Status read result available |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_data | output | 8 | Status read result |
| wp_n | input | 1 | Active-low lock pin |
| arr_busy | input | 1 | Array write cycle in progress |
| arr_done | input | 1 | Array write cycle finished (pulse) |
| busy | output | 1 | Any internal write cycle in progress |
| wen | output | 1 | Write-enable latch |
| chk_addr | input | ADDR_W | Address to test for writability |
| chk_writable | output | 1 | Address may be written now |

## Verification
The hardest case to reach is the pin lock. Before `wp_n` can matter, a status write must first commit the lock-enable bit through a full write cycle while the pin is high. The stimulus does that commit, then drops `wp_n` with the latch still set. It then shows that a second status write starts no cycle and that `chk_writable` still reports the array as writable. The 0xFF busy read is reached the same way, by issuing a read inside the timed window of a status write and again while `arr_busy` is held.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [1:0] {
    OP_SETWE = 2'b00,
    OP_CLRWE = 2'b01,
    OP_RDST  = 2'b10,
    OP_WRST  = 2'b11
  } sr_op_e;

  localparam int B_BUSY = 0;
  localparam int B_WE   = 1;
  localparam int B_SEL0 = 2;
  localparam int B_SEL1 = 3;
  localparam int B_LOCK = 7;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] sel;
  } sr_nv_t;
endpackage

// File: rtl/sr_wcycle_timer.sv
module sr_wcycle_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LAST;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt) < CYCLES));
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/sr_range_decode.sv
module sr_range_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        sel,
  output logic              guarded
);
  always_comb begin
    unique case (sel)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = (addr[ADDR_W-1 -: 2] == 2'b11);
      2'b10:   guarded = addr[ADDR_W-1];
      default: guarded = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_rsp_slot.sv
module sr_rsp_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  output logic       can_load,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data
);
  assign can_load = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load && can_load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
  import sr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WR_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  input  logic              wp_n,
  input  logic              arr_busy,
  input  logic              arr_done,
  output logic              busy,
  output logic              wen,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_writable
);
  sr_op_e     op;
  sr_nv_t     nv_q, nv_pend;
  logic       we_q, fire, hw_lock, wr_go, rd_load;
  logic       cyc_busy, cyc_done, slot_free, guarded;
  logic [7:0] status_word;

  assign op        = sr_op_e'(cmd_op);
  assign cmd_ready = slot_free;
  assign fire      = cmd_valid && cmd_ready;
  assign busy      = cyc_busy || arr_busy;
  assign wen       = we_q;
  assign hw_lock   = !wp_n && nv_q.lock_en;
  assign wr_go     = fire && (op == OP_WRST) && !busy && we_q && !hw_lock;
  assign rd_load   = fire && (op == OP_RDST);

  always_comb begin
    status_word         = '0;
    status_word[B_BUSY] = 1'b0;
    status_word[B_WE]   = we_q;
    status_word[B_SEL0] = nv_q.sel[0];
    status_word[B_SEL1] = nv_q.sel[1];
    status_word[B_LOCK] = nv_q.lock_en;
    if (busy) status_word = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
    end else if (cyc_done || arr_done) begin
      we_q <= 1'b0;
    end else if (fire && !busy) begin
      if (op == OP_SETWE)      we_q <= 1'b1;
      else if (op == OP_CLRWE) we_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q    <= '0;
      nv_pend <= '0;
    end else begin
      if (wr_go) begin
        nv_pend.lock_en <= cmd_data[B_LOCK];
        nv_pend.sel     <= {cmd_data[B_SEL1], cmd_data[B_SEL0]};
      end
      if (cyc_done) nv_q <= nv_pend;
    end
  end

  sr_wcycle_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_go), .busy(cyc_busy), .done(cyc_done)
  );

  sr_rsp_slot u_slot (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .load_data(status_word),
    .can_load(slot_free), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  sr_range_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(chk_addr), .sel(nv_q.sel), .guarded(guarded)
  );

  assign chk_writable = we_q && !guarded;

  p_nv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_done |=> $stable(nv_q));
  p_we_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !we_q);
  p_lock_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_WRST && !busy && hw_lock) |=> !cyc_busy);
  p_busy_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_load && busy) |=> (rsp_data == 8'hFF));
  p_full_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_q.sel == 2'b11) |-> !chk_writable);
  p_drop_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && busy && op == OP_SETWE && !we_q) |=> !we_q);
  p_arr_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_done |=> !we_q);
endmodule

// File: tb/sr_protect_unit_bench.sv
module sr_protect_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 0;
  logic [7:0]  cmd_data = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [7:0]  rsp_data;
  logic        wp_n = 1;
  logic        arr_busy = 0;
  logic        arr_done = 0;
  logic        busy;
  logic        wen;
  logic [11:0] chk_addr = 0;
  logic        chk_writable;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sr_protect_unit u_sr_protect_unit (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic read_sr(output logic [7:0] d);
    send(2'b10, 8'h00);
    @(negedge clk);
    d = rsp_data;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic wr_check(logic [11:0] a, logic exp, string req);
    chk_addr = a; #1;
    chk(req, {7'd0, chk_writable}, {7'd0, exp});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R1 busy", {7'd0, busy}, 0);
    chk("R1 wen", {7'd0, wen}, 0);
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 0);
    wr_check(12'h000, 0, "R1 writable");
    read_sr(d);
    chk("R1 status", d, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    send(2'b00, 0); @(negedge clk);
    chk("R2 set", {7'd0, wen}, 1);
    read_sr(d); chk("R3 status latch", d, 8'h02);
    wr_check(12'hFFF, 1, "R9 sel00 top");
    send(2'b01, 0); @(negedge clk);
    chk("R2 clear", {7'd0, wen}, 0);
  endtask

  task automatic t_wr_nolatch();
    logic [7:0] d;
    send(2'b11, 8'h8C); @(negedge clk);
    chk("R4 no start", {7'd0, busy}, 0);
    read_sr(d); chk("R4 unchanged", d, 8'h00);
  endtask

  task automatic t_wr_cycle();
    logic [7:0] d;
    send(2'b00, 0);
    send(2'b11, 8'h74); @(negedge clk);
    chk("R5 busy", {7'd0, busy}, 1);
    wr_check(12'hC00, 1, "R5 old sel during cycle");
    read_sr(d); chk("R5 ff", d, 8'hFF);
    wait_idle();
    read_sr(d); chk("R6 stored bits", d, 8'h04);
    send(2'b00, 0); @(negedge clk);
    wr_check(12'hBFF, 1, "R9 sel01 below");
    wr_check(12'hC00, 0, "R9 sel01 edge");
    send(2'b11, 8'h08); wait_idle();
    send(2'b00, 0); @(negedge clk);
    wr_check(12'h7FF, 1, "R9 sel10 below");
    wr_check(12'h800, 0, "R9 sel10 edge");
    send(2'b11, 8'h0C); wait_idle();
    send(2'b00, 0); @(negedge clk);
    wr_check(12'h000, 0, "R9 sel11 bottom");
  endtask

  task automatic t_lock();
    logic [7:0] d;
    send(2'b11, 8'h80); wait_idle();
    read_sr(d); chk("R6 lock bit", d, 8'h80);
    wp_n = 0;
    send(2'b00, 0);
    send(2'b11, 8'h00); @(negedge clk);
    chk("R4 locked no start", {7'd0, busy}, 0);
    read_sr(d); chk("R4 locked unchanged", d, 8'h82);
    wr_check(12'h000, 1, "R10 array not locked");
    wp_n = 1;
    send(2'b11, 8'h00); wait_idle();
    read_sr(d); chk("R4 unlocked write", d, 8'h00);
  endtask

  task automatic t_arr();
    logic [7:0] d;
    @(negedge clk); arr_busy = 1;
    send(2'b00, 0); @(negedge clk);
    chk("R7 set dropped", {7'd0, wen}, 0);
    read_sr(d); chk("R5 ff array busy", d, 8'hFF);
    arr_busy = 0;
    send(2'b00, 0);
    @(negedge clk); arr_busy = 1;
    send(2'b01, 0); @(negedge clk);
    chk("R7 clear dropped", {7'd0, wen}, 1);
    arr_done = 1; @(negedge clk); arr_done = 0; arr_busy = 0;
    chk("R8 done clears", {7'd0, wen}, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] d;
    rsp_ready = 0;
    send(2'b10, 0);
    @(negedge clk);
    d = rsp_data;
    chk("R11 valid", {7'd0, rsp_valid}, 1);
    chk("R11 cmd_ready", {7'd0, cmd_ready}, 0);
    repeat (3) @(negedge clk);
    chk("R11 still valid", {7'd0, rsp_valid}, 1);
    chk("R11 data stable", rsp_data, d);
    rsp_ready = 1;
    @(negedge clk);
    chk("R11 drained", {7'd0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_latch();
    t_wr_nolatch();
    t_wr_cycle();
    t_lock();
    t_arr();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule